// File: doc/BRIEF.md
# Banked Direct-Page Address Generator

This block forms 24-bit effective addresses for a processor core that splits memory into 64 KiB banks. It holds two registers: an 8-bit data bank register, which supplies the bank for absolute-class accesses, and a 16-bit direct page register, which marks the base of a 256-byte window used by direct-page accesses. A request names an addressing class and carries a 16-bit operand. After a fixed number of cycles the block returns the address with a one-cycle valid strobe.

Direct-page addresses are the page base plus an 8-bit offset. The sum normally stays in bank 0, but a base of 0xFF01 or above can carry past 0xFFFF, and that carry moves the access into bank 1. When the low byte of the base is zero no carry is possible, so the result is ready in one cycle. Otherwise a second cycle propagates the carry through the upper byte. A single-chip mode input forces the bank field to zero for every access.

The controller has two states. ST_IDLE accepts requests. An accepted direct-page request with a nonzero base low byte moves it to ST_CARRY. Every other accepted request leaves it in ST_IDLE. ST_CARRY always returns to ST_IDLE after one cycle, and it raises busy while it is active.

Top module: `dp_addr_gen`

## Requirements
- R1: After reset the data bank register is 0x00 and the direct page register is 0x0000. busy and addr_valid are low.
- R2: An accepted absolute-class request returns {bank register, operand[15:0]} with addr_valid high one cycle after the accepting edge.
- R3: The data bank register changes only on a cycle with bank_wr high. Direct page writes and requests leave it unchanged.
- R4: A direct-page request returns the direct page register plus operand[7:0], zero-extended. operand[15:8] has no effect.
- R5: When the direct-page sum exceeds 0xFFFF, address bit 16 is set. A base of 0xFFFF with offset 0xFF gives 0x0100FE.
- R6: When bits 7:0 of the direct page register are 0x00, a direct-page result is valid one cycle after acceptance.
- R7: When bits 7:0 of the direct page register are nonzero, the result is valid two cycles after acceptance, with busy high in the cycle between. A request presented while busy is high is dropped and produces no result.
- R8: While single_chip is high when a request is accepted, address bits 23:16 are 0x00 for both classes. The data bank register keeps its contents and applies again once single_chip is low.
- R9: A register write in the same cycle as an accepted request, or during busy, affects only later requests. The result uses the values sampled at acceptance.
- R10: req_class encodes 0 as absolute class and 1 as direct-page class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| single_chip | input | 1 | Forces the bank field to zero |
| bank_wr | input | 1 | Load command for the data bank register |
| bank_wdata | input | 8 | New data bank value |
| page_wr | input | 1 | Write strobe for the direct page register |
| page_wdata | input | 16 | New direct page base |
| req | input | 1 | Address request, accepted when busy is low |
| req_class | input | 1 | 0 absolute, 1 direct page |
| req_operand | input | 16 | Absolute address or 8-bit offset in bits 7:0 |
| busy | output | 1 | Second cycle of a carry calculation in progress |
| addr_valid | output | 1 | Result strobe |
| addr_out | output | 24 | Effective address |

## Verification
Register writes and address requests can arrive in the same cycle. The bench provokes this by asserting bank_wr or page_wr on the very cycle a request is accepted, and again during the busy cycle of a two-cycle calculation. The scoreboard computes each expected address from the register values held before the write, and then the address for the next request from the values after it. A request driven during busy checks that the block drops it: the monitor flags any extra strobe.

// File: rtl/agen_pkg.sv
package agen_pkg;
    typedef enum logic {
        CLS_ABS = 1'b0,
        CLS_DP  = 1'b1
    } agen_class_e;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_CARRY = 1'b1
    } agen_state_e;
endpackage

// File: rtl/agen_lane_add.sv
module agen_lane_add #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] full;

    always_comb begin
        full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        sum  = full[W-1:0];
        cout = full[W];
    end
endmodule

// File: rtl/agen_regs.sv
module agen_regs #(
    parameter int BANK_W = 8,
    parameter int OFS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_wr,
    input  logic [BANK_W-1:0] bank_wdata,
    input  logic              page_wr,
    input  logic [OFS_W-1:0]  page_wdata,
    output logic [BANK_W-1:0] bank_q,
    output logic [OFS_W-1:0]  page_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (bank_wr) begin
            bank_q <= bank_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (page_wr) begin
            page_q <= page_wdata;
        end
    end

    assert_bank_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_wr |=> $stable(bank_q));

    assert_page_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !page_wr |=> $stable(page_q));
endmodule

// File: rtl/agen_ctrl.sv
module agen_ctrl
    import agen_pkg::*;
#(
    parameter int BANK_W     = 8,
    parameter int OFS_W      = 16,
    parameter int PAGE_OFS_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req,
    input  agen_class_e             req_class,
    input  logic [OFS_W-1:0]        req_operand,
    input  logic                    single_chip,
    input  logic [BANK_W-1:0]       bank_q,
    input  logic [OFS_W-1:0]        page_q,
    output logic                    busy,
    output logic                    addr_valid,
    output logic [BANK_W+OFS_W-1:0] addr_out
);
    localparam int ADDR_W = BANK_W + OFS_W;
    localparam int HI_W   = OFS_W - PAGE_OFS_W;

    agen_state_e state_q, state_d;

    logic                  accept;
    logic                  lo_zero;
    logic                  slow_path;
    logic [PAGE_OFS_W-1:0] lo_sum;
    logic                  lo_cout;
    logic [PAGE_OFS_W-1:0] hold_lo;
    logic                  hold_carry;
    logic [HI_W-1:0]       hold_hi_base;
    logic                  hold_sc;
    logic [HI_W-1:0]       hi_sum;
    logic                  hi_cout;
    logic [BANK_W-1:0]     abs_bank;
    logic [BANK_W-1:0]     carry_bank;

    assign accept    = req && (state_q == ST_IDLE);
    assign lo_zero   = (page_q[PAGE_OFS_W-1:0] == '0);
    assign slow_path = (req_class == CLS_DP) && !lo_zero;
    assign busy      = (state_q == ST_CARRY);
    assign abs_bank  = single_chip ? '0 : bank_q;

    agen_lane_add #(.W(PAGE_OFS_W)) u_lo_add (
        .a    (page_q[PAGE_OFS_W-1:0]),
        .b    (req_operand[PAGE_OFS_W-1:0]),
        .cin  (1'b0),
        .sum  (lo_sum),
        .cout (lo_cout)
    );

    agen_lane_add #(.W(HI_W)) u_hi_add (
        .a    (hold_hi_base),
        .b    ({HI_W{1'b0}}),
        .cin  (hold_carry),
        .sum  (hi_sum),
        .cout (hi_cout)
    );

    assign carry_bank = {{(BANK_W-1){1'b0}}, hi_cout && !hold_sc};

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept && slow_path) state_d = ST_CARRY;
            ST_CARRY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Capture of the first stage for the carry cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_lo      <= '0;
            hold_carry   <= 1'b0;
            hold_hi_base <= '0;
            hold_sc      <= 1'b0;
        end else if (accept && slow_path) begin
            hold_lo      <= lo_sum;
            hold_carry   <= lo_cout;
            hold_hi_base <= page_q[OFS_W-1:PAGE_OFS_W];
            hold_sc      <= single_chip;
        end
    end

    // Output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_valid <= 1'b0;
            addr_out   <= '0;
        end else begin
            addr_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept && (req_class == CLS_ABS)) begin
                        addr_valid <= 1'b1;
                        addr_out   <= {abs_bank, req_operand};
                    end else if (accept && !slow_path) begin
                        addr_valid <= 1'b1;
                        addr_out   <= {{BANK_W{1'b0}}, page_q[OFS_W-1:PAGE_OFS_W],
                                       req_operand[PAGE_OFS_W-1:0]};
                    end
                end
                ST_CARRY: begin
                    addr_valid <= 1'b1;
                    addr_out   <= {carry_bank, hi_sum, hold_lo};
                end
                default: addr_valid <= 1'b0;
            endcase
        end
    end

    assert_abs_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (req_class == CLS_ABS) |=> addr_valid && !busy);

    assert_fast_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (req_class == CLS_DP) && lo_zero |=> addr_valid && !busy);

    assert_slow_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accept && slow_path |=> busy && !addr_valid ##1 addr_valid);

    assert_busy_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    assert_sc_fast_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept && single_chip && !slow_path |=> addr_out[ADDR_W-1:OFS_W] == '0);

    assert_sc_slow_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept && single_chip && slow_path |=> ##1 addr_out[ADDR_W-1:OFS_W] == '0);

    assert_carry_bank1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy && hold_carry && !hold_sc && (&hold_hi_base) |=> addr_out[OFS_W]);
endmodule

// File: rtl/dp_addr_gen.sv
module dp_addr_gen
    import agen_pkg::*;
#(
    parameter int BANK_W     = 8,
    parameter int OFS_W      = 16,
    parameter int PAGE_OFS_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    single_chip,
    input  logic                    bank_wr,
    input  logic [BANK_W-1:0]       bank_wdata,
    input  logic                    page_wr,
    input  logic [OFS_W-1:0]        page_wdata,
    input  logic                    req,
    input  logic                    req_class,
    input  logic [OFS_W-1:0]        req_operand,
    output logic                    busy,
    output logic                    addr_valid,
    output logic [BANK_W+OFS_W-1:0] addr_out
);
    logic [BANK_W-1:0] bank_q;
    logic [OFS_W-1:0]  page_q;
    agen_class_e       cls;

    assign cls = agen_class_e'(req_class);

    agen_regs #(.BANK_W(BANK_W), .OFS_W(OFS_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bank_wr    (bank_wr),
        .bank_wdata (bank_wdata),
        .page_wr    (page_wr),
        .page_wdata (page_wdata),
        .bank_q     (bank_q),
        .page_q     (page_q)
    );

    agen_ctrl #(.BANK_W(BANK_W), .OFS_W(OFS_W), .PAGE_OFS_W(PAGE_OFS_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .req_class   (cls),
        .req_operand (req_operand),
        .single_chip (single_chip),
        .bank_q      (bank_q),
        .page_q      (page_q),
        .busy        (busy),
        .addr_valid  (addr_valid),
        .addr_out    (addr_out)
    );

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !busy && !addr_valid);
endmodule

// File: tb/test_dp_addr_gen.sv
module test_dp_addr_gen;
    typedef struct {
        logic [23:0] addr;
        int          cyc;
        string       tag;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        single_chip = 1'b0;
    logic        bank_wr = 1'b0;
    logic [7:0]  bank_wdata = '0;
    logic        page_wr = 1'b0;
    logic [15:0] page_wdata = '0;
    logic        req = 1'b0;
    logic        req_class = 1'b0;
    logic [15:0] req_operand = '0;
    logic        busy;
    logic        addr_valid;
    logic [23:0] addr_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;
    bit mon_on = 0;
    sb_item_t sb[$];

    logic [7:0]  bank_m = 8'h00;
    logic [15:0] page_m = 16'h0000;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dp_addr_gen i_dp_addr_gen (
        .clk(clk), .rst_n(rst_n), .single_chip(single_chip),
        .bank_wr(bank_wr), .bank_wdata(bank_wdata),
        .page_wr(page_wr), .page_wdata(page_wdata),
        .req(req), .req_class(req_class), .req_operand(req_operand),
        .busy(busy), .addr_valid(addr_valid), .addr_out(addr_out)
    );

    function automatic logic [23:0] model_addr(input logic cls, input logic [15:0] op);
        logic [16:0] s;
        if (!cls) return {single_chip ? 8'h00 : bank_m, op};
        s = {1'b0, page_m} + {9'b0, op[7:0]};
        return {7'b0, s[16] & ~single_chip, s[15:0]};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: request, optionally with same-cycle register writes (R9)
    task automatic issue(input logic cls, input logic [15:0] op, input bit wb, input logic [7:0] bv,
                         input bit wp, input logic [15:0] pv, input string tag);
        int lat;
        @(negedge clk);
        lat = (cls && page_m[7:0] != 8'h00) ? 2 : 1;
        sb.push_back('{model_addr(cls, op), cyc + lat, tag});
        req = 1'b1; req_class = cls; req_operand = op;
        bank_wr = wb; bank_wdata = bv; page_wr = wp; page_wdata = pv;
        @(negedge clk);
        req = 1'b0; bank_wr = 1'b0; page_wr = 1'b0;
        if (wb) bank_m = bv;
        if (wp) page_m = pv;
    endtask

    task automatic wr_bank(input logic [7:0] v);
        @(negedge clk); bank_wr = 1'b1; bank_wdata = v;
        @(negedge clk); bank_wr = 1'b0; bank_m = v;
    endtask

    task automatic wr_page(input logic [15:0] v);
        @(negedge clk); page_wr = 1'b1; page_wdata = v;
        @(negedge clk); page_wr = 1'b0; page_m = v;
    endtask

    // Monitor: compares address and arrival cycle
    always @(negedge clk) begin
        if (mon_on) begin
            if (addr_valid) begin
                if (sb.size() == 0) begin
                    check(0, "R7 unexpected result", {8'h0, addr_out}, 32'h0);
                end else begin
                    check(addr_out == sb[0].addr, {sb[0].tag, " address"}, {8'h0, addr_out}, {8'h0, sb[0].addr});
                    check(cyc == sb[0].cyc, {sb[0].tag, " latency"}, cyc, sb[0].cyc);
                    void'(sb.pop_front());
                end
            end else if (sb.size() != 0 && sb[0].cyc <= cyc) begin
                check(0, {sb[0].tag, " missing result"}, cyc, sb[0].cyc);
                void'(sb.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        check(addr_valid == 1'b0, "R1 valid after reset", addr_valid, 0);
        mon_on = 1;

        issue(1'b0, 16'h1234, 0, 0, 0, 0, "R1 R2 R10 absolute after reset");
        issue(1'b1, 16'hAB55, 0, 0, 0, 0, "R1 R4 R6 direct upper byte ignored");
        wr_bank(8'h5A);
        issue(1'b0, 16'hBEEF, 0, 0, 0, 0, "R2 R3 absolute with bank");
        wr_page(16'h1200);
        issue(1'b1, 16'h0034, 0, 0, 0, 0, "R6 zero low byte");
        issue(1'b0, 16'h0001, 0, 0, 0, 0, "R3 bank unchanged by page write");
        wr_page(16'h12F0);
        issue(1'b1, 16'h0020, 0, 0, 0, 0, "R7 nonzero low byte");
        wr_page(16'hFFFF);
        issue(1'b1, 16'h00FF, 0, 0, 0, 0, "R5 carry 0x0100FE");
        wr_page(16'hFF01);
        issue(1'b1, 16'h00FF, 0, 0, 0, 0, "R5 carry 0x010000");
        wr_page(16'hFF00);
        issue(1'b1, 16'h00FF, 0, 0, 0, 0, "R5 R6 no carry 0x00FFFF");

        // R7: request during busy is dropped
        wr_page(16'h0010);
        issue(1'b1, 16'h0005, 0, 0, 0, 0, "R7 slow before blocked request");
        check(busy == 1'b1, "R7 busy in carry cycle", busy, 1);
        req = 1'b1; req_class = 1'b0; req_operand = 16'h7777;
        @(negedge clk);
        req = 1'b0;
        check(busy == 1'b0, "R7 busy released", busy, 0);

        // R8 single-chip mode
        single_chip = 1'b1;
        issue(1'b0, 16'h4321, 0, 0, 0, 0, "R8 absolute bank forced zero");
        wr_page(16'hFFFF);
        issue(1'b1, 16'h00FF, 0, 0, 0, 0, "R8 direct carry suppressed");
        single_chip = 1'b0;
        issue(1'b0, 16'h4321, 0, 0, 0, 0, "R8 bank retained");

        // R9 same-cycle writes
        issue(1'b0, 16'h1111, 1, 8'hC3, 0, 0, "R9 old bank used");
        issue(1'b0, 16'h2222, 0, 0, 0, 0, "R9 new bank used");
        wr_page(16'h0101);
        issue(1'b1, 16'h0002, 0, 0, 1, 16'h0000, "R9 old page used");
        page_wr = 1'b1; page_wdata = 16'h3000;
        @(negedge clk);
        page_wr = 1'b0; page_m = 16'h3000;
        issue(1'b1, 16'h0002, 0, 0, 0, 0, "R9 write during busy applied later");

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R2 scoreboard drained", sb.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule